// File: doc/BRIEF.md
# Flash Program/Erase Sequencer Model

This block is a synthesizable behavioural model of a word-wide flash array and the controller that programs and erases it. The array is split into five blocks held in on-chip registers. A small boot block sits at address 0, followed by two parameter blocks and two main blocks. Each block size is a parameter. A single-cycle command port starts operations: word program, block erase, chip erase, erase suspend, erase resume and read/reset. The model keeps to flash semantics. A program can only clear bits. Only an erase can set them back to one, and it does so for whole blocks.

A block erase opens a short collection window. During that window, more block-erase commands add blocks to the pending set. When the window closes, the blocks are erased one after another, lowest index first, each taking a fixed number of cycles. A running erase can be suspended. While it is suspended, the other blocks can be read and programmed. On resume, the erase continues the same block from the count it had left. A fault input marks one word as defective so that the failure path can be driven: the failing program or erase leaves its target unchanged and raises an error. Once the error is raised, only the read/reset command is accepted.

A read port gives array data combinationally, together with a flag that says whether the addressed word is readable. A separate status block watches the busy, error, erase-phase, suspend and pending-set flags.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset every word reads all ones. `st_busy`, `st_err`, `st_ers_active` and `st_susp` are low, and `st_pend` is zero.
- R2: Block index 0 is the boot block at addresses 0 to BOOT_WORDS-1. Index 1 and index 2 are the parameter blocks, and index 3 and index 4 are the main blocks, placed in that order above it. Bit i of `st_pend` stands for block i.
- R3: A program command (`cmd_op` = 1) makes the word equal to its old value AND `cmd_data`, so a 0 bit never returns to 1. `st_busy` is high from the edge that accepts the command until exactly PROG_CYC edges later, when the new value becomes visible.
- R4: A block-erase command (`cmd_op` = 2) from idle opens a window of ERASE_WIN edges. A block-erase command accepted at any edge of that window adds its block to `st_pend`, including at the closing edge. The pending blocks are then erased lowest index first, ERASE_CYC edges each. Every word of an erased block becomes all ones.
- R5: Once erasing has started (`st_ers_active` high), block-erase commands are ignored: the pending set does not grow, and blocks outside it keep their data.
- R6: A chip-erase command (`cmd_op` = 3) from idle skips the window and sets all five pending bits. It finishes after 5*ERASE_CYC edges with the whole array at all ones.
- R7: `rd_ok` is low while a program runs and for any word whose block is pending. Otherwise `rd_ok` is high and `rd_data` is the stored word.
- R8: A suspend command (`cmd_op` = 4) during a running erase freezes it at once. `st_susp` goes high and `st_busy` goes low. If the suspend arrives at the edge where a block's count ends, the suspend wins and that block is not yet erased.
- R9: While suspended, a program to a block outside the pending set runs normally and then returns to the suspended state. A program to a pending block is ignored.
- R10: A resume command (`cmd_op` = 5) continues the suspended block with its remaining count. The block completes after that count plus one edge.
- R11: With `flt_en` high, a program of word `flt_addr` leaves the word unchanged and sets `st_err`. An erase that includes the block of `flt_addr` leaves that block unchanged, erases the other pending blocks, and sets `st_err` when the last block ends.
- R12: While `st_err` is high, every command except read/reset (`cmd_op` = 0) is ignored. Read/reset clears the error and returns to idle.
- R13: Command codes 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | AW | Word address of program or block erase |
| cmd_data | input | DW | Program data |
| flt_en | input | 1 | Enable fault injection |
| flt_addr | input | AW | Word (and its block) forced to fail |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Stored word at `rd_addr` |
| rd_ok | output | 1 | Read data is valid |
| st_busy | output | 1 | Program or erase in progress |
| st_err | output | 1 | Operation failed |
| st_ers_active | output | 1 | Erase phase started (running or suspended) |
| st_susp | output | 1 | Erase suspended |
| st_pend | output | 5 | Blocks still to be erased |

## Verification
Two events can fall in the same cycle. The first is a block-erase command arriving at the closing edge of the collection window. The bench times the second command to land on that edge and expects both blocks in `st_pend`, with the erase phase already begun. The second is a suspend arriving at the edge where a block's erase count runs out. The bench counts the edges to land the suspend there. It expects the block to remain pending with `st_susp` high, and to complete one edge after resume.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int NBLK   = 5;
    localparam int BIDX_W = 3;

    typedef logic [NBLK-1:0]   bmask_t;
    typedef logic [BIDX_W-1:0] bidx_t;

    typedef enum logic [2:0] {
        OP_RESET   = 3'd0,
        OP_PROG    = 3'd1,
        OP_BERASE  = 3'd2,
        OP_CERASE  = 3'd3,
        OP_SUSPEND = 3'd4,
        OP_RESUME  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROG,
        S_EWAIT,
        S_ERUN,
        S_ESUSP,
        S_SPROG,
        S_ERR
    } state_e;

    typedef struct packed {
        logic   busy;
        logic   err;
        logic   ers_active;
        logic   susp;
        bmask_t pend;
    } stat_t;

    // block index of a word: boot, param0, param1, main0, main1
    function automatic int blk_of(int a, int boot, int prm, int mn);
        if (a < boot)               return 0;
        if (a < boot + prm)         return 1;
        if (a < boot + 2*prm)       return 2;
        if (a < boot + 2*prm + mn)  return 3;
        return 4;
    endfunction

    // lowest set bit of a block mask
    function automatic bidx_t first_blk(bmask_t m);
        bidx_t r;
        r = '0;
        for (int i = NBLK-1; i >= 0; i--) begin
            if (m[i]) r = bidx_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/fps_blkmap.sv
module fps_blkmap
    import fps_pkg::*;
#(
    parameter int AW          = 6,
    parameter int BOOT_WORDS  = 8,
    parameter int PARAM_WORDS = 4,
    parameter int MAIN_WORDS  = 16
) (
    input  logic [AW-1:0] addr,
    output bidx_t         blk,
    output logic          in_range
);
    localparam int TOTAL = BOOT_WORDS + 2*PARAM_WORDS + 2*MAIN_WORDS;

    always_comb begin
        blk      = bidx_t'(blk_of(int'(addr), BOOT_WORDS, PARAM_WORDS, MAIN_WORDS));
        in_range = int'(addr) < TOTAL;
    end
endmodule

// File: rtl/fps_array.sv
module fps_array
    import fps_pkg::*;
#(
    parameter int DW          = 16,
    parameter int AW          = 6,
    parameter int BOOT_WORDS  = 8,
    parameter int PARAM_WORDS = 4,
    parameter int MAIN_WORDS  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_en,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    input  logic          ers_en,
    input  bidx_t         ers_blk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int TOTAL = BOOT_WORDS + 2*PARAM_WORDS + 2*MAIN_WORDS;

    logic [DW-1:0] mem [TOTAL];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < TOTAL; w++) mem[w] <= '1;
        end else begin
            for (int w = 0; w < TOTAL; w++) begin
                if (ers_en && int'(ers_blk) == blk_of(w, BOOT_WORDS, PARAM_WORDS, MAIN_WORDS))
                    mem[w] <= '1;
                else if (prog_en && int'(prog_addr) == w)
                    mem[w] <= mem[w] & prog_data;   // bits only fall
            end
        end
    end

    always_comb begin
        rd_data = '1;
        if (int'(rd_addr) < TOTAL) rd_data = mem[rd_addr];
    end
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 6,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 12,
    parameter int ERASE_WIN = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  op_e           cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  bidx_t         cmd_blk,
    input  logic          cmd_in,
    input  logic          flt_en,
    input  logic [AW-1:0] flt_addr,
    input  bidx_t         flt_blk,
    input  logic          flt_in,
    output logic          prog_en,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          ers_en,
    output bidx_t         ers_blk,
    output logic          prog_act,
    output stat_t         stat
);
    localparam int PCW  = $clog2(PROG_CYC + 1);
    localparam int EMAX = (ERASE_CYC > ERASE_WIN) ? ERASE_CYC : ERASE_WIN;
    localparam int ECW  = $clog2(EMAX + 1);

    state_e         st_q;
    logic [PCW-1:0] pcnt_q;
    logic [ECW-1:0] ecnt_q;
    bmask_t         pend_q;
    bidx_t          cur_q;
    logic           fail_q;
    logic [AW-1:0]  pa_q;
    logic [DW-1:0]  pd_q;

    logic   is_cmd [8];
    logic   pzero, ezero, prog_bad, ers_bad, prog_done, ers_done, fail_n;
    bmask_t rest, add_mask;

    always_comb begin
        for (int k = 0; k < 8; k++) is_cmd[k] = cmd_valid && (int'(cmd_op) == k);
        pzero     = pcnt_q == '0;
        ezero     = ecnt_q == '0;
        prog_bad  = flt_en && flt_in && (flt_addr == pa_q);
        ers_bad   = flt_en && flt_in && (flt_blk == cur_q);
        prog_done = (st_q == S_PROG || st_q == S_SPROG) && pzero;
        ers_done  = (st_q == S_ERUN) && ezero && !is_cmd[OP_SUSPEND];
        fail_n    = fail_q | ers_bad;
        rest      = pend_q & ~(bmask_t'(1) << cur_q);
        add_mask  = (is_cmd[OP_BERASE] && cmd_in) ? (bmask_t'(1) << cmd_blk) : '0;

        prog_en   = prog_done && !prog_bad;
        prog_addr = pa_q;
        prog_data = pd_q;
        ers_en    = ers_done && !ers_bad;
        ers_blk   = cur_q;
        prog_act  = (st_q == S_PROG) || (st_q == S_SPROG);

        stat.busy       = (st_q == S_PROG) || (st_q == S_EWAIT) ||
                          (st_q == S_ERUN) || (st_q == S_SPROG);
        stat.err        = st_q == S_ERR;
        stat.ers_active = (st_q == S_ERUN) || (st_q == S_ESUSP) || (st_q == S_SPROG);
        stat.susp       = (st_q == S_ESUSP) || (st_q == S_SPROG);
        stat.pend       = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            pcnt_q <= '0;
            ecnt_q <= '0;
            pend_q <= '0;
            cur_q  <= '0;
            fail_q <= 1'b0;
            pa_q   <= '0;
            pd_q   <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (is_cmd[OP_PROG] && cmd_in) begin
                        st_q   <= S_PROG;
                        pcnt_q <= PCW'(PROG_CYC - 1);
                        pa_q   <= cmd_addr;
                        pd_q   <= cmd_data;
                    end else if (is_cmd[OP_BERASE] && cmd_in) begin
                        st_q   <= S_EWAIT;
                        pend_q <= add_mask;
                        ecnt_q <= ECW'(ERASE_WIN - 1);
                        fail_q <= 1'b0;
                    end else if (is_cmd[OP_CERASE]) begin
                        st_q   <= S_ERUN;
                        pend_q <= '1;
                        cur_q  <= '0;
                        ecnt_q <= ECW'(ERASE_CYC - 1);
                        fail_q <= 1'b0;
                    end
                end
                S_PROG: begin
                    if (pzero) st_q <= prog_bad ? S_ERR : S_IDLE;
                    else       pcnt_q <= pcnt_q - 1'b1;
                end
                S_EWAIT: begin
                    pend_q <= pend_q | add_mask;
                    if (ezero) begin
                        st_q   <= S_ERUN;
                        cur_q  <= first_blk(pend_q | add_mask);
                        ecnt_q <= ECW'(ERASE_CYC - 1);
                    end else begin
                        ecnt_q <= ecnt_q - 1'b1;
                    end
                end
                S_ERUN: begin
                    if (is_cmd[OP_SUSPEND]) begin
                        st_q <= S_ESUSP;              // count frozen
                    end else if (ezero) begin
                        if (rest == '0) begin
                            st_q   <= fail_n ? S_ERR : S_IDLE;
                            pend_q <= '0;
                        end else begin
                            pend_q <= rest;
                            cur_q  <= first_blk(rest);
                            ecnt_q <= ECW'(ERASE_CYC - 1);
                            fail_q <= fail_n;
                        end
                    end else begin
                        ecnt_q <= ecnt_q - 1'b1;
                    end
                end
                S_ESUSP: begin
                    if (is_cmd[OP_RESUME]) begin
                        st_q <= S_ERUN;
                    end else if (is_cmd[OP_PROG] && cmd_in && !pend_q[cmd_blk]) begin
                        st_q   <= S_SPROG;
                        pcnt_q <= PCW'(PROG_CYC - 1);
                        pa_q   <= cmd_addr;
                        pd_q   <= cmd_data;
                    end
                end
                S_SPROG: begin
                    if (pzero) begin
                        if (prog_bad) begin
                            st_q   <= S_ERR;
                            pend_q <= '0;
                        end else begin
                            st_q <= S_ESUSP;
                        end
                    end else begin
                        pcnt_q <= pcnt_q - 1'b1;
                    end
                end
                S_ERR: begin
                    if (is_cmd[OP_RESET]) st_q <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import fps_pkg::*;
#(
    parameter int DW          = 16,
    parameter int BOOT_WORDS  = 8,
    parameter int PARAM_WORDS = 4,
    parameter int MAIN_WORDS  = 16,
    parameter int PROG_CYC    = 4,
    parameter int ERASE_CYC   = 12,
    parameter int ERASE_WIN   = 6,
    parameter int AW          = $clog2(BOOT_WORDS + 2*PARAM_WORDS + 2*MAIN_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          flt_en,
    input  logic [AW-1:0] flt_addr,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_ok,
    output logic          st_busy,
    output logic          st_err,
    output logic          st_ers_active,
    output logic          st_susp,
    output logic [4:0]    st_pend
);
    bidx_t         cmd_blk, flt_blk, rd_blk, ers_blk;
    logic          cmd_in, flt_in, rd_in;
    logic          prog_en, ers_en, prog_act;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;
    stat_t         stat;

    fps_blkmap #(.AW(AW), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS),
                 .MAIN_WORDS(MAIN_WORDS))
        u_map_cmd (.addr(cmd_addr), .blk(cmd_blk), .in_range(cmd_in));

    fps_blkmap #(.AW(AW), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS),
                 .MAIN_WORDS(MAIN_WORDS))
        u_map_flt (.addr(flt_addr), .blk(flt_blk), .in_range(flt_in));

    fps_blkmap #(.AW(AW), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS),
                 .MAIN_WORDS(MAIN_WORDS))
        u_map_rd (.addr(rd_addr), .blk(rd_blk), .in_range(rd_in));

    fps_ctrl #(.DW(DW), .AW(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
               .ERASE_WIN(ERASE_WIN))
        u_ctrl (
            .clk      (clk),
            .rst      (rst),
            .cmd_valid(cmd_valid),
            .cmd_op   (op_e'(cmd_op)),
            .cmd_addr (cmd_addr),
            .cmd_data (cmd_data),
            .cmd_blk  (cmd_blk),
            .cmd_in   (cmd_in),
            .flt_en   (flt_en),
            .flt_addr (flt_addr),
            .flt_blk  (flt_blk),
            .flt_in   (flt_in),
            .prog_en  (prog_en),
            .prog_addr(prog_addr),
            .prog_data(prog_data),
            .ers_en   (ers_en),
            .ers_blk  (ers_blk),
            .prog_act (prog_act),
            .stat     (stat)
        );

    fps_array #(.DW(DW), .AW(AW), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS),
                .MAIN_WORDS(MAIN_WORDS))
        u_array (
            .clk      (clk),
            .rst      (rst),
            .prog_en  (prog_en),
            .prog_addr(prog_addr),
            .prog_data(prog_data),
            .ers_en   (ers_en),
            .ers_blk  (ers_blk),
            .rd_addr  (rd_addr),
            .rd_data  (rd_data)
        );

    always_comb begin
        st_busy       = stat.busy;
        st_err        = stat.err;
        st_ers_active = stat.ers_active;
        st_susp       = stat.susp;
        st_pend       = stat.pend;
        rd_ok         = rd_in && !prog_act && !stat.pend[rd_blk];
    end
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       rd_ok,
    input logic       st_busy,
    input logic       st_err,
    input logic       st_ers_active,
    input logic       st_susp,
    input logic [4:0] st_pend
);
    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        st_err && !(cmd_valid && cmd_op == 3'd0) |=> st_err);

    // R11
    err_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
        st_err |-> st_pend == 5'd0);

    // R8
    susp_in_erase_chk: assert property (@(posedge clk) disable iff (rst)
        st_susp |-> st_ers_active);

    // R5
    pend_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
        st_ers_active && $past(st_ers_active) |-> (st_pend & ~$past(st_pend)) == 5'd0);

    // R7
    prog_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
        st_busy && !st_ers_active && st_pend == 5'd0 |-> !rd_ok);
endmodule

bind flash_pe_seq flash_pe_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .rd_ok        (rd_ok),
    .st_busy      (st_busy),
    .st_err       (st_err),
    .st_ers_active(st_ers_active),
    .st_susp      (st_susp),
    .st_pend      (st_pend)
);

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;
    localparam int DW   = 16;
    localparam int BOOT = 4;
    localparam int PRM  = 2;
    localparam int MN   = 4;
    localparam int TOT  = BOOT + 2*PRM + 2*MN;
    localparam int AW   = 4;
    localparam int PC   = 3;
    localparam int EC   = 8;
    localparam int EW   = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic          flt_en;
    logic [AW-1:0] flt_addr;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          rd_ok;
    logic          st_busy, st_err, st_ers_active, st_susp;
    logic [4:0]    st_pend;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] model [TOT];

    always #4 clk = ~clk;

    flash_pe_seq #(.DW(DW), .BOOT_WORDS(BOOT), .PARAM_WORDS(PRM), .MAIN_WORDS(MN),
                   .PROG_CYC(PC), .ERASE_CYC(EC), .ERASE_WIN(EW), .AW(AW))
        u_flash_pe_seq (
            .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
            .cmd_addr(cmd_addr), .cmd_data(cmd_data), .flt_en(flt_en),
            .flt_addr(flt_addr), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ok(rd_ok),
            .st_busy(st_busy), .st_err(st_err), .st_ers_active(st_ers_active),
            .st_susp(st_susp), .st_pend(st_pend));

    function automatic int bblk(int a);
        if (a < BOOT) return 0;
        if (a < BOOT + PRM) return 1;
        if (a < BOOT + 2*PRM) return 2;
        if (a < BOOT + 2*PRM + MN) return 3;
        return 4;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic issue(logic [2:0] op, int a, logic [DW-1:0] d);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = AW'(a);
        cmd_data  = d;
        tick(1);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(int a, output logic [DW-1:0] d, output logic ok);
        rd_addr = AW'(a);
        #1;
        d  = rd_data;
        ok = rd_ok;
    endtask

    task automatic check_all(string req);
        logic [DW-1:0] d;
        logic ok;
        for (int a = 0; a < TOT; a++) begin
            rd(a, d, ok);
            chk(req, {31'd0, ok}, 32'd1);
            chk(req, {16'd0, d}, {16'd0, model[a]});
        end
    endtask

    task automatic prog(int a, logic [DW-1:0] d);
        issue(3'd1, a, d);
        tick(PC);
        model[a] = model[a] & d;
    endtask

    task automatic erase_model(int b);
        for (int a = 0; a < TOT; a++) if (bblk(a) == b) model[a] = '1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d;
        logic ok;
        int w3, w4;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
        flt_en = 1'b0; flt_addr = '0; rd_addr = '0;
        for (int a = 0; a < TOT; a++) model[a] = '1;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk("R1 busy", {31'd0, st_busy}, 0);
        chk("R1 err", {31'd0, st_err}, 0);
        chk("R1 susp", {31'd0, st_susp}, 0);
        chk("R1 pend", {27'd0, st_pend}, 0);
        check_all("R1 array");

        // R13 unused code
        issue(3'd7, 0, 16'h0000);
        chk("R13 busy", {31'd0, st_busy}, 0);
        tick(PC);
        rd(0, d, ok);
        chk("R13 data", {16'd0, d}, 32'h0000FFFF);

        // R3 program sweep with exact busy window, R7 read gating
        for (int a = 0; a < TOT; a++) begin
            logic [DW-1:0] pd;
            pd = 16'hF0F0 ^ DW'(a * 16'h0911);
            issue(3'd1, a, pd);
            chk("R3 busy start", {31'd0, st_busy}, 1);
            rd(a, d, ok);
            chk("R7 ok during program", {31'd0, ok}, 0);
            tick(PC - 1);
            chk("R3 busy last", {31'd0, st_busy}, 1);
            tick(1);
            chk("R3 busy end", {31'd0, st_busy}, 0);
            model[a] = model[a] & pd;
        end
        check_all("R3 first pass");
        for (int a = 0; a < TOT; a++) prog(a, ~DW'(a * 16'h1357) ^ 16'h00FF);
        check_all("R3 zeros stay");

        // R4 single block erase of block 1, R2 pend bit
        issue(3'd2, BOOT, 16'h0000);
        chk("R2 pend bit", {27'd0, st_pend}, 32'h02);
        rd(BOOT, d, ok);
        chk("R7 pending not ok", {31'd0, ok}, 0);
        rd(0, d, ok);
        chk("R7 other ok", {31'd0, ok}, 1);
        tick(EW - 1);
        chk("R4 window", {31'd0, st_ers_active}, 0);
        tick(1);
        chk("R4 run", {31'd0, st_ers_active}, 1);
        tick(EC - 1);
        chk("R4 busy", {31'd0, st_busy}, 1);
        tick(1);
        chk("R4 done", {31'd0, st_busy}, 0);
        erase_model(1);
        check_all("R4 single");

        // R4 add at closing edge of window, R5 late add ignored
        issue(3'd2, BOOT + 2*PRM, 16'h0000);
        tick(EW - 1);
        issue(3'd2, 0, 16'h0000);
        chk("R4 late add pend", {27'd0, st_pend}, 32'h09);
        chk("R4 run begun", {31'd0, st_ers_active}, 1);
        issue(3'd2, TOT - 1, 16'h0000);
        chk("R5 pend fixed", {27'd0, st_pend}, 32'h09);
        tick(2*EC - 2);
        chk("R4 lowest first", {27'd0, st_pend}, 32'h08);
        chk("R4 busy", {31'd0, st_busy}, 1);
        tick(1);
        chk("R4 multi done", {31'd0, st_busy}, 0);
        erase_model(0);
        erase_model(3);
        check_all("R5 others kept");

        // R6 chip erase
        prog(1, 16'h1234);
        prog(TOT - 1, 16'h4321);
        issue(3'd3, 0, 16'h0000);
        chk("R6 pend", {27'd0, st_pend}, 32'h1F);
        tick(5*EC - 1);
        chk("R6 busy", {31'd0, st_busy}, 1);
        tick(1);
        chk("R6 done", {31'd0, st_busy}, 0);
        for (int a = 0; a < TOT; a++) model[a] = '1;
        check_all("R6 array");

        // R8 R9 R10 suspend, program elsewhere, resume
        w3 = BOOT + 2*PRM;
        w4 = TOT - 2;
        prog(w4, 16'h0F0F);
        prog(w3, 16'h3C3C);
        issue(3'd2, w3, 16'h0000);
        tick(EW);
        tick(2);
        issue(3'd4, 0, 16'h0000);
        chk("R8 susp", {31'd0, st_susp}, 1);
        chk("R8 not busy", {31'd0, st_busy}, 0);
        rd(w4, d, ok);
        chk("R9 read other ok", {31'd0, ok}, 1);
        chk("R9 read other data", {16'd0, d}, {16'd0, model[w4]});
        rd(w3, d, ok);
        chk("R7 pending hidden", {31'd0, ok}, 0);
        tick(5);
        chk("R8 still susp", {31'd0, st_susp}, 1);
        issue(3'd1, w3, 16'h0000);
        chk("R9 pending prog ignored", {31'd0, st_busy}, 0);
        issue(3'd1, w4, 16'h00FF);
        chk("R9 prog runs", {31'd0, st_busy}, 1);
        tick(PC);
        chk("R9 back to susp", {31'd0, st_susp}, 1);
        chk("R9 idle in susp", {31'd0, st_busy}, 0);
        model[w4] = model[w4] & 16'h00FF;
        rd(w4, d, ok);
        chk("R9 prog data", {16'd0, d}, {16'd0, model[w4]});
        issue(3'd5, 0, 16'h0000);
        tick(EC - 3);
        chk("R10 busy", {31'd0, st_busy}, 1);
        tick(1);
        chk("R10 done", {31'd0, st_busy}, 0);
        erase_model(3);
        check_all("R10 array");

        // R8 suspend on completion edge
        issue(3'd2, w4, 16'h0000);
        tick(EW);
        tick(EC - 1);
        issue(3'd4, 0, 16'h0000);
        chk("R8 collide susp", {31'd0, st_susp}, 1);
        chk("R8 collide pend", {27'd0, st_pend}, 32'h10);
        issue(3'd5, 0, 16'h0000);
        chk("R10 resume busy", {31'd0, st_busy}, 1);
        tick(1);
        chk("R10 one edge", {31'd0, st_busy}, 0);
        erase_model(4);
        rd(w4, d, ok);
        chk("R8 erased after resume", {16'd0, d}, 32'h0000FFFF);

        // R11 program fault, R12 error lock and reset
        prog(2, 16'h5555);
        flt_en = 1'b1;
        flt_addr = AW'(2);
        issue(3'd1, 2, 16'h0000);
        tick(PC);
        chk("R11 err", {31'd0, st_err}, 1);
        chk("R11 not busy", {31'd0, st_busy}, 0);
        rd(2, d, ok);
        chk("R11 word kept", {16'd0, d}, {16'd0, model[2]});
        issue(3'd1, 5, 16'h0000);
        tick(PC);
        chk("R12 err held", {31'd0, st_err}, 1);
        rd(5, d, ok);
        chk("R12 prog ignored", {16'd0, d}, {16'd0, model[5]});
        issue(3'd0, 0, 16'h0000);
        chk("R12 cleared", {31'd0, st_err}, 0);

        // R11 erase fault on block 1
        flt_en = 1'b0;
        prog(BOOT, 16'h0000);
        prog(BOOT + PRM, 16'h0000);
        flt_en = 1'b1;
        flt_addr = AW'(BOOT);
        issue(3'd2, BOOT, 16'h0000);
        issue(3'd2, BOOT + PRM, 16'h0000);
        tick(EW + 2*EC - 2);
        chk("R11 still busy", {31'd0, st_busy}, 1);
        chk("R11 err late", {31'd0, st_err}, 0);
        tick(1);
        chk("R11 erase err", {31'd0, st_err}, 1);
        erase_model(2);
        rd(BOOT, d, ok);
        chk("R11 bad block kept", {16'd0, d}, 32'h0);
        rd(BOOT + PRM, d, ok);
        chk("R11 good block erased", {16'd0, d}, 32'h0000FFFF);
        issue(3'd0, 0, 16'h0000);
        chk("R12 reset", {31'd0, st_err}, 0);
        flt_en = 1'b0;
        check_all("R12 final");

        finish_run();
    end
endmodule